// File: doc/BRIEF.md
# Pluggable Module Bring-Up Sequencer

This block walks a pluggable optical module from reset to a lit transmitter in a fixed order. First the management side must report ready. Next, every supply rail must hold its power-good input for a qualification window. Then the electrical front-end is told to start training, and the laser bias is soft-started. The optical power loop is switched on only after the bias has reached its target. The transmitter is never enabled until training has reported lock.

Each state has a defined way out when something goes wrong. If a rail droops during training, during the bias ramp or while running, the block drops back to rail qualification. If lock is lost, the laser is disabled and the block waits a fixed hold-off before it retrains. If training does not lock within a window, it is restarted. Timeouts and lock losses both draw on a retry budget. When that budget is spent, the block enters a latched failure state. A protection or over-temperature fault shuts the transmitter off and is reported in the state code. A saturating counter records how many times lock was lost, so that repeated relock loops are visible.

Top module: `plug_bringup_seq`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied, the block holds `state_code` at 0, `train_start`, `tx_en` and `apc_en` at 0, and `bias_code` and `relock_cnt` at 0. The state codes are: 0 wait for management, 1 rail qualification, 2 training, 3 bias ramp, 4 running, 5 hold-off, 6 fault, 7 failed.
- R2: The block leaves state 0 only while `mgmt_rdy` is 1. In state 1 it advances to training only after every bit of `rail_pg` has been 1 for `STABLE_CYC` consecutive clock edges. A low pulse on any rail restarts that rail's window, so the block moves to state 2 exactly `STABLE_CYC`+1 cycles after the last rail rises.
- R3: On every entry into training, and on every restart of training, `train_start` is 1 for exactly the first cycle. In state 2, `train_lock` equal to 1 moves the block to state 3.
- R4: `tx_en` is 1 only in states 3 and 4. It therefore rises only on the step from training into the ramp.
- R5: In state 3, `bias_code` starts from 0, rises by `RAMP_STEP` once every `RAMP_DIV` cycles and stops at `BIAS_TARGET`. The block enters state 4 on the cycle after the target is reached, so the ramp takes `RAMP_DIV`*(`BIAS_TARGET`/`RAMP_STEP`)+1 cycles. `apc_en` is 1 only in state 4. In every other state, `bias_code` falls by `RAMP_STEP` per `RAMP_DIV` cycles until it reaches 0.
- R6: If any `rail_pg` bit is 0 while the block is in state 2, 3, 4 or 5, and no fault is present, the block is in state 1 on the next cycle with `tx_en` at 0.
- R7: If training does not lock within `TRAIN_TIMEOUT` cycles, training restarts. `train_start` pulses again exactly `TRAIN_TIMEOUT` cycles after the previous pulse, and one retry is used.
- R8: If `train_lock` falls in state 3 or 4, the block enters hold-off (state 5) with `tx_en` and `apc_en` at 0. It stays there for exactly `REENABLE_DLY` cycles and then retrains. The loss uses one retry.
- R9: `fault` equal to 1 in any state other than 7 moves the block to state 6 on the next cycle, with `tx_en` and `apc_en` at 0. The block stays in state 6 while `fault` is 1, and returns to state 0 once `fault` clears.
- R10: When the retry count reaches `RETRY_LIMIT`, the block enters state 7. It stays there, ignoring `fault`, `train_lock` and the rails, until reset.
- R11: `relock_cnt` goes up by one on each lock loss in state 3 or 4, never goes down, and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mgmt_rdy | input | 1 | Management side is ready |
| rail_pg | input | NUM_RAILS | Power-good input for each supply rail |
| train_lock | input | 1 | Training has converged / lock held |
| fault | input | 1 | Protection or over-temperature fault |
| train_start | output | 1 | One-cycle strobe that starts training |
| bias_code | output | BIAS_W | Laser bias code driven by the soft-start ramp |
| apc_en | output | 1 | Enable for the optical power loop |
| tx_en | output | 1 | Transmitter enable |
| state_code | output | 3 | Current sequencer state |
| relock_cnt | output | 8 | Saturating count of lock losses |

## Verification
The rail-droop property assumes that a rail drop seen in states 2 to 5 happens with `fault` low, because a fault takes priority. The bench applies every droop with `fault` held at 0. The hold-off and ramp-length checks assume that `train_lock` is constant within each phase. The stimulus changes lock only at defined points: while running to cause a loss, during hold-off where lock is ignored, or at the first cycle of training. All inputs change on falling edges, so each state the scoreboard observes lasts at least one full cycle.

// File: rtl/plug_bringup_pkg.sv
package plug_bringup_pkg;

    // Sequencer states; the numeric codes are visible on state_code.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RAILS   = 3'd1,
        ST_TRAIN   = 3'd2,
        ST_RAMP    = 3'd3,
        ST_ACTIVE  = 3'd4,
        ST_HOLDOFF = 3'd5,
        ST_FAULT   = 3'd6,
        ST_FAILED  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/plug_rail_qual.sv
// Per-rail stability qualifier: each rail must stay good for STABLE_CYC edges.
module plug_rail_qual #(
    parameter int NUM_RAILS  = 3,
    parameter int STABLE_CYC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_pg,
    output logic                 all_stable
);
    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(STABLE_CYC);

    logic [NUM_RAILS-1:0] rail_ok;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            if (!rail_pg[g]) begin
                cnt_d = '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_d = cnt_q + 1'b1;
            end else begin
                cnt_d = cnt_q;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign rail_ok[g] = (cnt_q == CNT_MAX);
    end

    assign all_stable = (&rail_ok) & (&rail_pg);

endmodule

// File: rtl/plug_bias_ramp.sv
// Soft-start bias generator: steps toward target (up) or zero (down).
module plug_bias_ramp #(
    parameter int BIAS_W      = 8,
    parameter int BIAS_TARGET = 32,
    parameter int RAMP_STEP   = 8,
    parameter int RAMP_DIV    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ramp_up,
    output logic [BIAS_W-1:0] bias,
    output logic              at_target
);
    localparam int DW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
    localparam logic [DW-1:0]   DIV_LAST = DW'(RAMP_DIV - 1);
    localparam logic [BIAS_W:0] TGT_X    = (BIAS_W + 1)'(BIAS_TARGET);
    localparam logic [BIAS_W:0] STEP_X   = (BIAS_W + 1)'(RAMP_STEP);

    typedef struct packed {
        logic [BIAS_W-1:0] bias;
        logic [DW-1:0]     div;
    } ramp_t;

    ramp_t       r_d, r_q;
    logic        at_zero;
    logic        moving;
    logic        tick;
    logic [BIAS_W:0] up_sum;

    always_comb begin
        at_target = (r_q.bias == TGT_X[BIAS_W-1:0]);
        at_zero   = (r_q.bias == '0);
        moving    = ramp_up ? !at_target : !at_zero;
        tick      = moving && (r_q.div == DIV_LAST);
        up_sum    = {1'b0, r_q.bias} + STEP_X;

        r_d = r_q;
        // Prescaler rests at zero when the bias sits at its goal.
        if (!moving || tick) begin
            r_d.div = '0;
        end else begin
            r_d.div = r_q.div + 1'b1;
        end

        if (tick) begin
            if (ramp_up) begin
                r_d.bias = (up_sum >= TGT_X) ? TGT_X[BIAS_W-1:0] : up_sum[BIAS_W-1:0];
            end else if ({1'b0, r_q.bias} > STEP_X) begin
                r_d.bias = r_q.bias - STEP_X[BIAS_W-1:0];
            end else begin
                r_d.bias = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bias = r_q.bias;

endmodule

// File: rtl/plug_bringup_seq.sv
// Bring-up sequencer top: ordering, retraining, droop and fault handling.
module plug_bringup_seq
    import plug_bringup_pkg::*;
#(
    parameter int NUM_RAILS     = 3,
    parameter int STABLE_CYC    = 16,
    parameter int TRAIN_TIMEOUT = 64,
    parameter int REENABLE_DLY  = 20,
    parameter int RETRY_LIMIT   = 3,
    parameter int BIAS_W        = 8,
    parameter int BIAS_TARGET   = 32,
    parameter int RAMP_STEP     = 8,
    parameter int RAMP_DIV      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mgmt_rdy,
    input  logic [NUM_RAILS-1:0] rail_pg,
    input  logic                 train_lock,
    input  logic                 fault,
    output logic                 train_start,
    output logic [BIAS_W-1:0]    bias_code,
    output logic                 apc_en,
    output logic                 tx_en,
    output logic [2:0]           state_code,
    output logic [7:0]           relock_cnt
);
    localparam int TMAX = (TRAIN_TIMEOUT > REENABLE_DLY) ? TRAIN_TIMEOUT : REENABLE_DLY;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(RETRY_LIMIT + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TRAIN_TIMEOUT - 1);
    localparam logic [TW-1:0] DLY_LAST = TW'(REENABLE_DLY - 1);
    localparam logic [RW-1:0] RET_LIM  = RW'(RETRY_LIMIT);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tmr;
        logic [RW-1:0] retry;
        logic [7:0]    relock;
        logic          strobe;
    } seq_t;

    seq_t          s_d, s_q;
    seq_state_e    nxt;
    logic          all_stable;
    logic          at_target;
    logic          rails_up;
    logic          restart_train;
    logic          lock_lost;
    logic          bump_retry;
    logic [RW-1:0] retry_inc;

    plug_rail_qual #(
        .NUM_RAILS (NUM_RAILS),
        .STABLE_CYC(STABLE_CYC)
    ) u_rails (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_pg   (rail_pg),
        .all_stable(all_stable)
    );

    plug_bias_ramp #(
        .BIAS_W     (BIAS_W),
        .BIAS_TARGET(BIAS_TARGET),
        .RAMP_STEP  (RAMP_STEP),
        .RAMP_DIV   (RAMP_DIV)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ramp_up  (tx_en),
        .bias     (bias_code),
        .at_target(at_target)
    );

    always_comb begin
        s_d           = s_q;
        nxt           = s_q.st;
        rails_up      = &rail_pg;
        restart_train = 1'b0;
        lock_lost     = 1'b0;
        bump_retry    = 1'b0;
        retry_inc     = s_q.retry + 1'b1;

        if (s_q.st != ST_FAILED && fault) begin
            nxt = ST_FAULT;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    if (mgmt_rdy) nxt = ST_RAILS;
                end
                ST_RAILS: begin
                    if (!mgmt_rdy)       nxt = ST_IDLE;
                    else if (all_stable) nxt = ST_TRAIN;
                end
                ST_TRAIN: begin
                    if (!rails_up) begin
                        nxt = ST_RAILS;
                    end else if (train_lock) begin
                        nxt = ST_RAMP;
                    end else if (s_q.tmr == TMO_LAST) begin
                        bump_retry    = 1'b1;
                        restart_train = 1'b1;
                    end
                end
                ST_RAMP: begin
                    if (!rails_up)        nxt = ST_RAILS;
                    else if (!train_lock) lock_lost = 1'b1;
                    else if (at_target)   nxt = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (!rails_up)        nxt = ST_RAILS;
                    else if (!train_lock) lock_lost = 1'b1;
                end
                ST_HOLDOFF: begin
                    if (!rails_up)                nxt = ST_RAILS;
                    else if (s_q.tmr == DLY_LAST) nxt = ST_TRAIN;
                end
                ST_FAULT: begin
                    if (!fault) nxt = ST_IDLE;
                end
                ST_FAILED: begin
                    nxt = ST_FAILED;
                end
                default: begin
                    nxt = ST_IDLE;
                end
            endcase
        end

        if (lock_lost) begin
            bump_retry = 1'b1;
            nxt        = ST_HOLDOFF;
            if (s_q.relock != 8'hFF) begin
                s_d.relock = s_q.relock + 8'd1;
            end
        end

        if (bump_retry) begin
            s_d.retry = retry_inc;
            if (retry_inc >= RET_LIM) begin
                nxt           = ST_FAILED;
                restart_train = 1'b0;
            end
        end

        s_d.st = nxt;
        if (nxt != s_q.st || restart_train) begin
            s_d.tmr = '0;
        end else if (s_q.tmr != '1) begin
            s_d.tmr = s_q.tmr + 1'b1;
        end

        s_d.strobe = (nxt == ST_TRAIN) && ((s_q.st != ST_TRAIN) || restart_train);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, tmr: '0, retry: '0, relock: '0, strobe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign train_start = s_q.strobe;
    assign state_code  = s_q.st;
    assign relock_cnt  = s_q.relock;
    assign tx_en       = (s_q.st == ST_RAMP) || (s_q.st == ST_ACTIVE);
    assign apc_en      = (s_q.st == ST_ACTIVE);

endmodule

// File: rtl/plug_bringup_chk.sv
// Temporal checks on the sequencer ports, bound into every instance.
module plug_bringup_chk #(
    parameter int NUM_RAILS   = 3,
    parameter int BIAS_W      = 8,
    parameter int BIAS_TARGET = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] rail_pg,
    input logic                 fault,
    input logic                 train_start,
    input logic [BIAS_W-1:0]    bias_code,
    input logic                 apc_en,
    input logic                 tx_en,
    input logic [2:0]           state_code,
    input logic [7:0]           relock_cnt
);
    localparam logic [BIAS_W-1:0] TGT = BIAS_W'(BIAS_TARGET);

    assert_strobe_in_train_R3: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |-> (state_code == 3'd2) && !tx_en);

    assert_tx_after_train_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> ($past(state_code) == 3'd2));

    assert_loop_after_ramp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        apc_en |-> (bias_code == TGT));

    assert_bias_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bias_code <= TGT);

    assert_droop_requal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !(&rail_pg) && (state_code inside {3'd2, 3'd3, 3'd4, 3'd5}))
        |=> (state_code == 3'd1) && !tx_en);

    assert_fault_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !tx_en && !apc_en);

    assert_failed_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd7) |=> (state_code == 3'd7));

    assert_relock_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_cnt != 8'hFF) |=> (relock_cnt >= $past(relock_cnt)));

    assert_relock_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_cnt == 8'hFF) |=> (relock_cnt == 8'hFF));

endmodule

bind plug_bringup_seq plug_bringup_chk #(
    .NUM_RAILS  (NUM_RAILS),
    .BIAS_W     (BIAS_W),
    .BIAS_TARGET(BIAS_TARGET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rail_pg    (rail_pg),
    .fault      (fault),
    .train_start(train_start),
    .bias_code  (bias_code),
    .apc_en     (apc_en),
    .tx_en      (tx_en),
    .state_code (state_code),
    .relock_cnt (relock_cnt)
);

// File: tb/plug_bringup_seq_tb.sv
module plug_bringup_seq_tb;

    localparam int NUM_RAILS     = 2;
    localparam int STABLE_CYC    = 8;
    localparam int TRAIN_TIMEOUT = 16;
    localparam int REENABLE_DLY  = 10;
    localparam int RETRY_LIMIT   = 260;
    localparam int BIAS_W        = 8;
    localparam int BIAS_TARGET   = 32;
    localparam int RAMP_STEP     = 8;
    localparam int RAMP_DIV      = 3;

    typedef struct {
        int    st;
        string req;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 mgmt_rdy;
    logic [NUM_RAILS-1:0] rail_pg;
    logic                 train_lock;
    logic                 fault;
    logic                 train_start;
    logic [BIAS_W-1:0]    bias_code;
    logic                 apc_en;
    logic                 tx_en;
    logic [2:0]           state_code;
    logic [7:0]           relock_cnt;

    int   n_vec = 0;
    int   n_bad = 0;
    int   prev_state = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    plug_bringup_seq #(
        .NUM_RAILS    (NUM_RAILS),
        .STABLE_CYC   (STABLE_CYC),
        .TRAIN_TIMEOUT(TRAIN_TIMEOUT),
        .REENABLE_DLY (REENABLE_DLY),
        .RETRY_LIMIT  (RETRY_LIMIT),
        .BIAS_W       (BIAS_W),
        .BIAS_TARGET  (BIAS_TARGET),
        .RAMP_STEP    (RAMP_STEP),
        .RAMP_DIV     (RAMP_DIV)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_rdy   (mgmt_rdy),
        .rail_pg    (rail_pg),
        .train_lock (train_lock),
        .fault      (fault),
        .train_start(train_start),
        .bias_code  (bias_code),
        .apc_en     (apc_en),
        .tx_en      (tx_en),
        .state_code (state_code),
        .relock_cnt (relock_cnt)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int st, string req);
        exp_t e;
        e.st  = st;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_st(int st, string req);
        int k = 0;
        while (int'(state_code) != st && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (int'(state_code) != st) chk(req, "state reached", int'(state_code), st);
    endtask

    // Scoreboard monitor: every state change must match the next expected item.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_state = 0;
        end else if (int'(state_code) != prev_state) begin
            if (exp_q.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R2 unexpected transition: actual %0d expected none (from %0d)",
                         state_code, prev_state);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.req, "state sequence", int'(state_code), e.st);
            end
            prev_state = int'(state_code);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1: actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int retries;
        int relocks;
        int n;
        rst_n      = 1'b0;
        mgmt_rdy   = 1'b0;
        rail_pg    = '0;
        train_lock = 1'b0;
        fault      = 1'b0;
        tick(3);
        chk("R1", "state in reset", int'(state_code), 0);
        chk("R1", "tx_en in reset", int'(tx_en), 0);
        chk("R1", "apc_en in reset", int'(apc_en), 0);
        chk("R1", "bias in reset", int'(bias_code), 0);
        chk("R1", "relock in reset", int'(relock_cnt), 0);
        chk("R1", "train_start in reset", int'(train_start), 0);
        rst_n = 1'b1;
        tick(5);
        chk("R2", "idle without mgmt", int'(state_code), 0);

        // R2: management ready then rail qualification with a glitch
        push(1, "R2");
        mgmt_rdy = 1'b1;
        wait_st(1, "R2");
        rail_pg = '1;
        tick(3);
        rail_pg[0] = 1'b0;
        tick(1);
        rail_pg[0] = 1'b1;
        push(2, "R3");
        n = 0;
        while (state_code == 3'd1 && n < 100) begin
            tick(1);
            n++;
        end
        chk("R2", "qualify cycles after glitch", n, STABLE_CYC + 1);

        // R3 / R7: strobe and training timeout
        chk("R3", "train_start on entry", int'(train_start), 1);
        chk("R4", "tx_en during training", int'(tx_en), 0);
        tick(1);
        chk("R3", "train_start single cycle", int'(train_start), 0);
        n = 1;
        while (!train_start && n < 200) begin
            tick(1);
            n++;
        end
        chk("R7", "cycles between strobes", n, TRAIN_TIMEOUT);
        chk("R7", "still training", int'(state_code), 2);
        retries = 1;
        relocks = 0;

        // R4 / R5: lock, ramp, run
        push(3, "R4");
        push(4, "R5");
        train_lock = 1'b1;
        wait_st(3, "R4");
        chk("R4", "tx_en in ramp", int'(tx_en), 1);
        chk("R5", "apc_en off in ramp", int'(apc_en), 0);
        n = 0;
        while (state_code == 3'd3 && n < 200) begin
            tick(1);
            n++;
        end
        chk("R5", "ramp length", n, RAMP_DIV * (BIAS_TARGET / RAMP_STEP) + 1);
        chk("R5", "bias at target", int'(bias_code), BIAS_TARGET);
        chk("R5", "apc_en when running", int'(apc_en), 1);

        // R8: lock loss, hold-off, retrain
        push(5, "R8");
        push(2, "R8");
        push(3, "R8");
        push(4, "R8");
        train_lock = 1'b0;
        tick(1);
        chk("R8", "hold-off entered", int'(state_code), 5);
        chk("R8", "tx_en in hold-off", int'(tx_en), 0);
        chk("R8", "apc_en in hold-off", int'(apc_en), 0);
        chk("R11", "relock count one", int'(relock_cnt), 1);
        train_lock = 1'b1;
        n = 0;
        while (state_code == 3'd5 && n < 200) begin
            tick(1);
            n++;
        end
        chk("R8", "hold-off length", n, REENABLE_DLY);
        chk("R5", "bias ramped down", int'(bias_code),
            BIAS_TARGET - (REENABLE_DLY / RAMP_DIV) * RAMP_STEP);
        wait_st(4, "R8");
        retries++;
        relocks++;

        // R6: rail droop while running
        push(1, "R6");
        push(2, "R6");
        push(3, "R6");
        push(4, "R6");
        rail_pg[1] = 1'b0;
        tick(1);
        chk("R6", "droop to rails", int'(state_code), 1);
        chk("R6", "tx_en after droop", int'(tx_en), 0);
        tick(1);
        rail_pg[1] = 1'b1;
        wait_st(4, "R6");

        // R9: fault
        push(6, "R9");
        fault = 1'b1;
        tick(1);
        chk("R9", "fault state", int'(state_code), 6);
        chk("R9", "tx_en on fault", int'(tx_en), 0);
        chk("R9", "apc_en on fault", int'(apc_en), 0);
        tick(4);
        chk("R9", "fault held", int'(state_code), 6);
        push(0, "R9");
        push(1, "R9");
        push(2, "R9");
        push(3, "R9");
        push(4, "R9");
        fault = 1'b0;
        wait_st(4, "R9");

        // R10 / R11: repeated relock loops until the retry budget is spent
        while (1) begin
            if (retries + 1 == RETRY_LIMIT) begin
                push(7, "R10");
                train_lock = 1'b0;
                relocks++;
                retries++;
                tick(1);
                break;
            end
            push(5, "R11");
            push(2, "R11");
            push(3, "R11");
            push(4, "R11");
            train_lock = 1'b0;
            relocks++;
            retries++;
            wait_st(5, "R11");
            train_lock = 1'b1;
            wait_st(4, "R11");
            if (relocks == 254 || relocks == 255 || relocks == 256)
                chk("R11", "relock count", int'(relock_cnt), (relocks > 255) ? 255 : relocks);
        end
        chk("R10", "failed state", int'(state_code), 7);
        chk("R10", "tx_en when failed", int'(tx_en), 0);
        chk("R11", "relock saturated", int'(relock_cnt), 255);
        fault      = 1'b1;
        train_lock = 1'b1;
        tick(10);
        chk("R10", "failed ignores fault", int'(state_code), 7);
        tick(20);
        chk("R5", "bias down when failed", int'(bias_code), 0);
        fault = 1'b0;
        tick(5);
        chk("R10", "failed latched", int'(state_code), 7);

        // R1: reset clears the latch and the counter
        rst_n    = 1'b0;
        mgmt_rdy = 1'b0;
        tick(2);
        chk("R1", "state after reset", int'(state_code), 0);
        chk("R1", "relock after reset", int'(relock_cnt), 0);
        rst_n = 1'b1;
        tick(3);
        chk("R2", "idle after reset", int'(state_code), 0);

        if (exp_q.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R2 missing transitions: actual %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule